// File: doc/BRIEF.md
# Challenge-Response Device Verifier

This block runs the verifier's side of a device authentication exchange. It holds a small table of challenge/response records, which are loaded through a plain write port. When a session starts, it draws `K` distinct table entries in pseudo-random order. For each entry it sends only the challenge half to the remote device. It then waits for the device's answer and compares that answer against the stored response, which never leaves the block.

A 16-bit LFSR runs freely and is reduced modulo the table depth to propose an entry. A proposal that is already used in the current session is skipped. The session stops at the first wrong answer, or at an answer that does not come within a bounded number of cycles. In either case it reports done with fail, and the stream-enable output stays low. If all `K` answers match, it reports done with pass and raises stream-enable. The result is held until the next start.

Top module: `crv_verifier`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `fail_o`, `stream_en_o` and `chal_valid_o` are all low.
- R2: A passing session that follows `start_i` puts out exactly `K` challenges. Each one is a one-cycle `chal_valid_o` pulse, and `chal_data_o` carries the challenge stored in some table entry. `chal_data_o` is zero while `chal_valid_o` is low.
- R3: Within one session, no table entry is picked twice. With distinct stored challenges, all `K` challenges are distinct.
- R4: Each answer is the first `resp_valid_i` cycle after its challenge. It is compared with the response stored in the same entry. If all `K` answers match, the block raises `done_o`, `pass_o` and `stream_en_o`, and `fail_o` stays low.
- R5: The first non-matching answer ends the session. The block raises `done_o` and `fail_o`, keeps `stream_en_o` low, and sends no further challenge.
- R6: After a challenge pulse, the answer window is `TIMEOUT` cycles, counted from the cycle after the pulse. An answer in the last of those cycles is accepted. If no answer comes in the window, the session ends with `done_o` and `fail_o`.
- R7: `start_i` has no effect while a session runs. `resp_valid_i` has no effect while the block is not waiting for an answer.
- R8: The result outputs hold their values until the next accepted `start_i`, which clears them on the following cycle.
- R9: `pass_o` and `fail_o` are never high together.
- R10: A write through `wr_en_i` replaces both halves of the addressed entry, and later sessions compare against the new response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | IDX_W | Table entry to write |
| wr_chal_i | input | CH_W | Challenge to store |
| wr_resp_i | input | RS_W | Expected response to store |
| start_i | input | 1 | Begin a session (ignored while busy) |
| chal_valid_o | output | 1 | Challenge beat valid |
| chal_data_o | output | CH_W | Challenge sent to the device |
| resp_valid_i | input | 1 | Device answer valid |
| resp_data_i | input | RS_W | Device answer |
| done_o | output | 1 | Session finished |
| pass_o | output | 1 | All answers matched |
| fail_o | output | 1 | Mismatch or timeout |
| stream_en_o | output | 1 | Enable for the protected stream |

## Verification
The bench loads a table with distinct challenges and answers from its own copy of that table. It runs sessions with immediate answers and with answers delayed to the last cycle of the window, which separates correct window counting from an off-by-one. Wrong answers are injected at the first and at the last challenge, which shows both that the comparison is made and that the session stops early. A dropped answer checks the timeout. Stray starts and answers tell ignored inputs apart from ones that restart or corrupt a session. A session after the responses are rewritten shows that the write port reaches the comparison.

// File: rtl/crv_pkg.sv
package crv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_SEND,
    ST_WAIT
  } crv_state_e;
endpackage

// File: rtl/crv_pair_table.sv
module crv_pair_table #(
  parameter int DEPTH = 16,
  parameter int CH_W  = 8,
  parameter int RS_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_chal_i,
  input  logic [RS_W-1:0]  wr_resp_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CH_W-1:0]  rd_chal_o,
  output logic [RS_W-1:0]  rd_resp_o
);
  logic [CH_W-1:0] chal_q [DEPTH];
  logic [RS_W-1:0] resp_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chal_q[i] <= '0;
        resp_q[i] <= '0;
      end else if (wr_en_i && wr_addr_i == IDX_W'(i)) begin
        chal_q[i] <= wr_chal_i;
        resp_q[i] <= wr_resp_i;
      end
    end
  end

  assign rd_chal_o = chal_q[rd_idx_i];
  assign rd_resp_o = resp_q[rd_idx_i];
endmodule

// File: rtl/crv_index_gen.sv
module crv_index_gen #(
  parameter int          DEPTH = 16,
  parameter logic [15:0] SEED  = 16'hACE1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             take_i,
  output logic [IDX_W-1:0] cand_o,
  output logic             cand_free_o
);
  logic [15:0]      lfsr_q;
  logic [15:0]      red;
  logic [DEPTH-1:0] used_q;

  // taps 16,14,13,11: maximal length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= SEED;
    else         lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  assign red         = lfsr_q % 16'(DEPTH);
  assign cand_o      = red[IDX_W-1:0];
  assign cand_free_o = !used_q[cand_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    used_q <= '0;
    else if (clear_i)               used_q <= '0;
    else if (take_i && cand_free_o) used_q[cand_o] <= 1'b1;
  end
endmodule

// File: rtl/crv_verifier.sv
module crv_verifier #(
  parameter int          DEPTH   = 16,
  parameter int          CH_W    = 8,
  parameter int          RS_W    = 8,
  parameter int          K       = 4,
  parameter int          TIMEOUT = 8,
  parameter logic [15:0] SEED    = 16'hACE1,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [CH_W-1:0]  wr_chal_i,
  input  logic [RS_W-1:0]  wr_resp_i,
  input  logic             start_i,
  output logic             chal_valid_o,
  output logic [CH_W-1:0]  chal_data_o,
  input  logic             resp_valid_i,
  input  logic [RS_W-1:0]  resp_data_i,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             stream_en_o
);
  import crv_pkg::*;

  localparam int CNT_W = $clog2(K + 1);
  localparam int TM_W  = $clog2(TIMEOUT + 1);

  crv_state_e       state_q;
  logic [IDX_W-1:0] idx_q, cand;
  logic             cand_free, take, clear;
  logic [CNT_W-1:0] cnt_q;
  logic [TM_W-1:0]  timer_q;
  logic             done_q, pass_q, fail_q;
  logic [CH_W-1:0]  rd_chal;
  logic [RS_W-1:0]  rd_resp;

  assign clear = (state_q == ST_IDLE) && start_i;
  assign take  = (state_q == ST_PICK) && cand_free;

  crv_pair_table #(.DEPTH(DEPTH), .CH_W(CH_W), .RS_W(RS_W)) u_table (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_chal_i, .wr_resp_i,
    .rd_idx_i(idx_q), .rd_chal_o(rd_chal), .rd_resp_o(rd_resp)
  );

  crv_index_gen #(.DEPTH(DEPTH), .SEED(SEED)) u_idx (
    .clk_i, .rst_ni, .clear_i(clear), .take_i(take),
    .cand_o(cand), .cand_free_o(cand_free)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      timer_q <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PICK;
          cnt_q   <= '0;
          done_q  <= 1'b0;
          pass_q  <= 1'b0;
          fail_q  <= 1'b0;
        end
        ST_PICK: if (cand_free) begin
          idx_q   <= cand;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          timer_q <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (resp_valid_i) begin
            if (resp_data_i != rd_resp) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              fail_q  <= 1'b1;
            end else if (cnt_q == CNT_W'(K - 1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_PICK;
            end
          end else if (timer_q == TM_W'(TIMEOUT - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign chal_valid_o = (state_q == ST_SEND);
  assign chal_data_o  = chal_valid_o ? rd_chal : '0;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign fail_o       = fail_q;
  assign stream_en_o  = pass_q;
endmodule

// File: rtl/crv_verifier_chk.sv
module crv_verifier_chk #(
  parameter int K       = 4,
  parameter int TIMEOUT = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic chal_valid_o,
  input logic resp_valid_i,
  input logic done_o,
  input logic pass_o,
  input logic fail_o,
  input logic stream_en_o
);
  localparam int TM_W = $clog2(TIMEOUT + 2) + 1;
  localparam int CN_W = $clog2(K + 2) + 1;

  logic            waiting_q, busy_q;
  logic [TM_W-1:0] wait_cnt_q;
  logic [CN_W-1:0] chal_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q  <= 1'b0;
      wait_cnt_q <= '0;
      busy_q     <= 1'b0;
      chal_cnt_q <= '0;
    end else begin
      if (chal_valid_o) begin
        waiting_q  <= 1'b1;
        wait_cnt_q <= '0;
      end else if (waiting_q) begin
        if (resp_valid_i || done_o) waiting_q <= 1'b0;
        else wait_cnt_q <= wait_cnt_q + 1'b1;
      end
      if (!busy_q && start_i) begin
        busy_q     <= 1'b1;
        chal_cnt_q <= '0;
      end else if (busy_q && done_o) begin
        busy_q <= 1'b0;
      end else if (chal_valid_o) begin
        chal_cnt_q <= chal_cnt_q + 1'b1;
      end
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !done_o && !chal_valid_o);
  p_chal_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chal_valid_o |=> !chal_valid_o);
  p_chal_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chal_cnt_q <= CN_W'(K));
  p_pass_stream_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> stream_en_o && done_o);
  p_fail_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !stream_en_o && done_o);
  p_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !chal_valid_o);
  p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    waiting_q |-> wait_cnt_q <= TM_W'(TIMEOUT));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(pass_o));
  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
endmodule

bind crv_verifier crv_verifier_chk #(.K(K), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i, .rst_ni, .start_i, .chal_valid_o, .resp_valid_i,
  .done_o, .pass_o, .fail_o, .stream_en_o
);

// File: tb/crv_verifier_bench.sv
module crv_verifier_bench;
  localparam int DEPTH = 16, CH_W = 8, RS_W = 8, K = 4, TIMEOUT = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0, rvalid = 1'b0;
  logic [IDX_W-1:0] wr_addr = '0;
  logic [CH_W-1:0] wr_chal = '0, cdata;
  logic [RS_W-1:0] wr_resp = '0, rdata = '0;
  logic cvalid, done, pass, fail, sen;

  logic [CH_W-1:0] m_chal [DEPTH];
  logic [RS_W-1:0] m_resp [DEPTH];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  crv_verifier #(.DEPTH(DEPTH), .CH_W(CH_W), .RS_W(RS_W), .K(K), .TIMEOUT(TIMEOUT)) u_crv_verifier (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_chal_i(wr_chal), .wr_resp_i(wr_resp), .start_i(start),
    .chal_valid_o(cvalid), .chal_data_o(cdata), .resp_valid_i(rvalid),
    .resp_data_i(rdata), .done_o(done), .pass_o(pass), .fail_o(fail),
    .stream_en_o(sen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] salt);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      m_chal[i] = 8'(i * 13 + 5);
      m_resp[i] = 8'(i * 29) ^ salt;
      wr_en = 1'b1; wr_addr = IDX_W'(i); wr_chal = m_chal[i]; wr_resp = m_resp[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int lookup(input logic [CH_W-1:0] c);
    for (int i = 0; i < DEPTH; i++) if (m_chal[i] == c) return i;
    return -1;
  endfunction

  // bad_at: index of wrong answer (-1 none); drop_at: index left unanswered
  task automatic session(input int bad_at, input int drop_at, input int delay,
                         input bit poke_start, output int n_chal);
    int seen [K];
    n_chal = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < K; k++) begin
      int t = 0, idx;
      while (!cvalid && t < 200) begin @(negedge clk); t++; end
      if (!cvalid) break;
      idx = lookup(cdata);
      chk(idx >= 0, "R2 challenge from table", int'(cdata), 0);
      for (int j = 0; j < n_chal; j++) chk(seen[j] != idx, "R3 entry reused", idx, -1);
      seen[n_chal] = idx;
      n_chal++;
      if (k == drop_at) begin
        repeat (TIMEOUT + 2) @(negedge clk);
        break;
      end
      for (int d = 0; d <= delay; d++) begin
        @(negedge clk);
        start = poke_start && d == 0;
      end
      start = 1'b0;
      rvalid = 1'b1;
      rdata = (idx >= 0 ? m_resp[idx] : '0) ^ RS_W'(k == bad_at);
      @(negedge clk);
      rvalid = 1'b0;
      chk(!cvalid, "R2 one-cycle pulse", int'(cvalid), 0);
      if (k == bad_at) break;
    end
  endtask

  task automatic t_reset();
    chk(!done && !pass && !fail && !sen && !cvalid && cdata == '0, "R1 reset outputs",
        {done, pass, fail, sen, cvalid}, 0);
  endtask

  task automatic t_pass(input int delay, input string tag);
    int n;
    session(-1, -1, delay, 1'b0, n);
    chk(n == K, {tag, " challenge count"}, n, K);
    chk(done && pass && !fail && sen, {tag, " pass flags"}, {done, pass, fail, sen}, 4'b1101);
  endtask

  task automatic t_mismatch(input int at);
    int n, extra = 0;
    session(at, -1, 0, 1'b0, n);
    chk(n == at + 1, "R5 stops at mismatch", n, at + 1);
    chk(done && fail && !pass && !sen, "R5 fail flags", {done, pass, fail, sen}, 4'b1010);
    repeat (20) begin @(negedge clk); if (cvalid) extra++; end
    chk(extra == 0, "R5 no challenge after fail", extra, 0);
  endtask

  task automatic t_timeout();
    int n;
    session(-1, 1, 0, 1'b0, n);
    chk(n == 2, "R6 challenges before drop", n, 2);
    chk(done && fail && !sen, "R6 timeout fails", {done, fail, sen}, 3'b110);
  endtask

  task automatic t_ignore();
    int n;
    session(-1, -1, 2, 1'b1, n);
    chk(n == K && pass, "R7 start ignored while busy", n, K);
    @(negedge clk); rvalid = 1'b1; rdata = 8'hFF;
    @(negedge clk); rvalid = 1'b0;
    repeat (20) @(negedge clk);
    chk(done && pass && !fail && sen, "R8 result held, R7 stray answer", {done, pass, fail, sen}, 4'b1101);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !pass && !fail && !sen, "R8 start clears", {done, pass, fail, sen}, 0);
    begin
      int t = 0;
      while (!cvalid && t < 200) begin @(negedge clk); t++; end
    end
    @(negedge clk); rvalid = 1'b1; rdata = m_resp[lookup(m_chal[0])] ^ 8'h80;
    repeat (TIMEOUT + 2) @(negedge clk);
    rvalid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_rewrite();
    int n;
    logic [7:0] old0 = m_resp[0];
    load(8'h5A);
    chk(m_resp[0] != old0, "R10 table changed", int'(m_resp[0]), int'(old0));
    t_pass(0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load(8'hA5);
    t_pass(0, "R4");
    t_pass(1, "R2");
    t_pass(TIMEOUT - 1, "R6 last window cycle");
    t_mismatch(0);
    t_mismatch(K - 1);
    t_timeout();
    t_ignore();
    t_rewrite();
    chk(!(pass && fail), "R9 exclusive", {pass, fail}, 2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule